// File: doc/BRIEF.md
# Two-Channel Hit Interval Calculator

This block turns a pair of timestamped hits, one on a start channel and one on a stop channel, into a signed time interval expressed in fine-time units. A free-running coarse counter advances once per clock. When a channel strobes its hit, the block latches the current counter value together with the calibrated fine time delivered with that strobe. The fine time of each channel is the distance from the hit to the next sampling edge.

When a stop hit arrives while a start stamp is pending, the pair is closed. The interval is formed as the whole-cycle difference times the number of fine units per clock, plus the start fine time, minus the stop fine time. The fine terms carry opposite signs because both are measured forward to an edge. Results are queued in a small first-in first-out buffer that the consumer drains with a pop strobe. The buffer flags when it is full and records any result lost to a full buffer.

The pairing logic is a two-state machine. `ST_IDLE` means no start is held. `ST_ARMED` means a start stamp is held. Its transitions are:
- `arm`: from idle on a start hit.
- `rearm`: armed to armed on a start hit, whether or not a stop arrives in the same cycle.
- `close`: armed to idle on a stop hit with no start hit.
- `stray`: idle to idle on a stop hit with no start hit.

Top module: `interval_calc`

## Requirements
- R1: After reset the buffer is empty (`res_avail`=0), `res_full`=0, `res_overflow`=0 and no start stamp is held.
- R2: A closed pair yields `res_data` = D·CLK_FINE + f1 − f2 as a two's-complement signed value. D is the number of clock edges from the start strobe to the stop strobe, f1 is the start fine time and f2 is the stop fine time.
- R3: D is taken modulo 2^CW, so a pair spanning a counter wrap yields the wrapped difference. For example, with CW=4 a gap of 18 edges gives D=2.
- R4: A start hit while a start is already held replaces the held stamp, and the later stamp is used for the interval.
- R5: A stop hit with no held start produces no result and leaves the block idle.
- R6: If start and stop strobe in the same cycle, the stop closes with the stamp held before that cycle (if any), and the start becomes the new held stamp. In idle, the stop is therefore discarded.
- R7: A result is written two clock edges after the stop strobe edge: `res_avail` is still 0 after the first edge and 1 after the second.
- R8: Each channel accepts a hit on every clock cycle, so a rate of one hit every other cycle is sustained with no loss.
- R9: Results leave the buffer in arrival order. `res_data` shows the oldest entry while `res_avail`=1, and `res_full`=1 exactly when DEPTH entries are held.
- R10: A result arriving while the buffer is full is dropped, stored entries are unchanged, and `res_overflow` goes to 1 and stays 1 until reset.
- R11: A pop while the buffer is empty has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the coarse count unit |
| rst_n | input | 1 | Active-low synchronous reset |
| ch1_hit | input | 1 | Start channel hit strobe |
| ch1_fine | input | FW | Start channel fine time, hit to next edge |
| ch2_hit | input | 1 | Stop channel hit strobe |
| ch2_fine | input | FW | Stop channel fine time, hit to next edge |
| res_pop | input | 1 | Removes the oldest buffered result |
| res_data | output | CW+clog2(CLK_FINE)+2 | Oldest buffered interval, signed, in fine units |
| res_avail | output | 1 | Buffer holds at least one result |
| res_full | output | 1 | Buffer holds DEPTH results |
| res_overflow | output | 1 | Sticky: a result was dropped |

## Verification
The bench builds the block with CW=4, FW=5, CLK_FINE=20 and DEPTH=4. With these values the coarse counter wraps every 16 cycles, so a sweep of start-to-stop gaps from 1 to 20 crosses the wrap and includes the zero-difference case, where negative intervals appear. Fine times are swept at both ends of their range. Because the buffer is only four entries deep, filling it, overflowing it and draining it all fit within a handful of pairs, next to the replacement, stray-stop and same-cycle orderings.

// File: rtl/interval_calc_pkg.sv
package interval_calc_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ARMED = 1'b1
    } arm_state_t;
endpackage

// File: rtl/ic_coarse_counter.sv
module ic_coarse_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [CW-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n) count <= '0;
        else        count <= count + 1'b1;
    end
endmodule

// File: rtl/ic_pair_fsm.sv
module ic_pair_fsm
    import interval_calc_pkg::*;
#(
    parameter int CW = 16,
    parameter int FW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] coarse,
    input  logic          start_hit,
    input  logic [FW-1:0] start_fine_in,
    input  logic          stop_hit,
    input  logic [FW-1:0] stop_fine_in,
    output logic          pending,
    output logic          pair_vld,
    output logic [CW-1:0] start_coarse,
    output logic [FW-1:0] start_fine,
    output logic [CW-1:0] stop_coarse,
    output logic [FW-1:0] stop_fine
);
    arm_state_t state, state_nxt;
    logic [CW-1:0] held_coarse;
    logic [FW-1:0] held_fine;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    // transitions: arm, rearm, close, stray
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_hit) state_nxt = ST_ARMED;
            end
            ST_ARMED: begin
                if (stop_hit && !start_hit) state_nxt = ST_IDLE;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // outputs: held stamp and closed pair
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_coarse  <= '0;
            held_fine    <= '0;
            pair_vld     <= 1'b0;
            start_coarse <= '0;
            start_fine   <= '0;
            stop_coarse  <= '0;
            stop_fine    <= '0;
        end else begin
            if (start_hit) begin
                held_coarse <= coarse;
                held_fine   <= start_fine_in;
            end
            pair_vld <= (state == ST_ARMED) && stop_hit;
            if ((state == ST_ARMED) && stop_hit) begin
                start_coarse <= held_coarse;
                start_fine   <= held_fine;
                stop_coarse  <= coarse;
                stop_fine    <= stop_fine_in;
            end
        end
    end

    assign pending = (state == ST_ARMED);
endmodule

// File: rtl/ic_interval_arith.sv
module ic_interval_arith #(
    parameter int CW       = 16,
    parameter int FW       = 12,
    parameter int CLK_FINE = 4000,
    parameter int RW       = 30
) (
    input  logic [CW-1:0]        start_coarse,
    input  logic [FW-1:0]        start_fine,
    input  logic [CW-1:0]        stop_coarse,
    input  logic [FW-1:0]        stop_fine,
    output logic signed [RW-1:0] interval
);
    logic [CW-1:0] cycles;
    logic [RW-1:0] span;

    always_comb begin
        cycles   = stop_coarse - start_coarse;
        span     = RW'(cycles) * RW'(CLK_FINE);
        interval = $signed(span + RW'(start_fine) - RW'(stop_fine));
    end
endmodule

// File: rtl/ic_result_fifo.sv
module ic_result_fifo #(
    parameter int RW    = 30,
    parameter int DEPTH = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic signed [RW-1:0] wr_data,
    input  logic                 rd_en,
    output logic signed [RW-1:0] rd_data,
    output logic                 not_empty,
    output logic                 full,
    output logic                 overflow
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic signed [RW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_wr, do_rd;

    assign full      = (count == (AW+1)'(DEPTH));
    assign not_empty = (count != '0);
    assign do_wr     = wr_en && !full;
    assign do_rd     = rd_en && not_empty;
    assign rd_data   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_wr) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (do_wr) wr_ptr <= (wr_ptr == AW'(DEPTH-1)) ? '0 : wr_ptr + 1'b1;
            if (do_rd) rd_ptr <= (rd_ptr == AW'(DEPTH-1)) ? '0 : rd_ptr + 1'b1;
            count <= count + (AW+1)'(do_wr) - (AW+1)'(do_rd);
            if (wr_en && full) overflow <= 1'b1;
        end
    end
endmodule

// File: rtl/interval_calc.sv
module interval_calc #(
    parameter int CW       = 16,
    parameter int FW       = 12,
    parameter int CLK_FINE = 4000,
    parameter int DEPTH    = 16,
    localparam int RW      = CW + $clog2(CLK_FINE) + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ch1_hit,
    input  logic [FW-1:0]        ch1_fine,
    input  logic                 ch2_hit,
    input  logic [FW-1:0]        ch2_fine,
    input  logic                 res_pop,
    output logic signed [RW-1:0] res_data,
    output logic                 res_avail,
    output logic                 res_full,
    output logic                 res_overflow
);
    logic [CW-1:0]        coarse;
    logic                 arm_pending;
    logic                 pair_vld;
    logic [CW-1:0]        p_start_c, p_stop_c;
    logic [FW-1:0]        p_start_f, p_stop_f;
    logic signed [RW-1:0] interval;

    ic_coarse_counter #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .count(coarse)
    );

    ic_pair_fsm #(.CW(CW), .FW(FW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .coarse(coarse),
        .start_hit(ch1_hit), .start_fine_in(ch1_fine),
        .stop_hit(ch2_hit), .stop_fine_in(ch2_fine),
        .pending(arm_pending), .pair_vld(pair_vld),
        .start_coarse(p_start_c), .start_fine(p_start_f),
        .stop_coarse(p_stop_c), .stop_fine(p_stop_f)
    );

    ic_interval_arith #(.CW(CW), .FW(FW), .CLK_FINE(CLK_FINE), .RW(RW)) u_arith (
        .start_coarse(p_start_c), .start_fine(p_start_f),
        .stop_coarse(p_stop_c), .stop_fine(p_stop_f),
        .interval(interval)
    );

    ic_result_fifo #(.RW(RW), .DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .wr_en(pair_vld), .wr_data(interval),
        .rd_en(res_pop), .rd_data(res_data),
        .not_empty(res_avail), .full(res_full), .overflow(res_overflow)
    );
endmodule

// File: rtl/interval_calc_chk.sv
module interval_calc_chk (
    input logic clk,
    input logic rst_n,
    input logic ch1_hit,
    input logic ch2_hit,
    input logic res_avail,
    input logic res_full,
    input logic res_overflow,
    input logic pending,
    input logic pair_vld
);
    a_r4_start_arms: assert property (@(posedge clk) disable iff (!rst_n)
        ch1_hit |=> pending);

    a_r5_stray_stop_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!pending && ch2_hit) |=> !pair_vld);

    a_r6_armed_stop_pairs: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && ch2_hit) |=> pair_vld);

    a_r7_result_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_vld && !res_full) |=> res_avail);

    a_r9_full_has_data: assert property (@(posedge clk) disable iff (!rst_n)
        res_full |-> res_avail);

    a_r10_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        res_overflow |=> res_overflow);

    a_r10_overflow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(res_overflow) |-> $past(res_full));

    a_r11_empty_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_avail && !pair_vld) |=> !res_avail);
endmodule

bind interval_calc interval_calc_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ch1_hit(ch1_hit), .ch2_hit(ch2_hit),
    .res_avail(res_avail), .res_full(res_full), .res_overflow(res_overflow),
    .pending(arm_pending), .pair_vld(pair_vld)
);

// File: tb/interval_calc_test.sv
module interval_calc_test;
    localparam int CW = 4;
    localparam int FW = 5;
    localparam int CLK_FINE = 20;
    localparam int DEPTH = 4;
    localparam int RW = CW + $clog2(CLK_FINE) + 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ch1_hit = 1'b0, ch2_hit = 1'b0, res_pop = 1'b0;
    logic [FW-1:0] ch1_fine = '0, ch2_fine = '0;
    logic signed [RW-1:0] res_data;
    logic res_avail, res_full, res_overflow;

    int checks = 0;
    int errors = 0;

    interval_calc #(.CW(CW), .FW(FW), .CLK_FINE(CLK_FINE), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n),
        .ch1_hit(ch1_hit), .ch1_fine(ch1_fine),
        .ch2_hit(ch2_hit), .ch2_fine(ch2_fine),
        .res_pop(res_pop), .res_data(res_data),
        .res_avail(res_avail), .res_full(res_full), .res_overflow(res_overflow)
    );

    always #5 clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic hit(input bit a, input bit b, input int f1, input int f2);
        ch1_hit = a; ch2_hit = b;
        ch1_fine = FW'(f1); ch2_fine = FW'(f2);
        @(negedge clk);
        ch1_hit = 1'b0; ch2_hit = 1'b0;
    endtask

    task automatic pop_check(input string tag, input int exp);
        check({tag, " avail"}, int'(res_avail), 1);
        check({tag, " data"}, int'(res_data), exp);
        res_pop = 1'b1;
        @(negedge clk);
        res_pop = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        idle(3);
        rst_n = 1'b1;
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        report();
    end

    initial begin
        do_reset();
        // R1 reset state
        check("R1 avail", int'(res_avail), 0);
        check("R1 full", int'(res_full), 0);
        check("R1 overflow", int'(res_overflow), 0);

        // R2 R3 R7: gap sweep across counter wrap, fine corners
        for (int gap = 1; gap <= 20; gap++) begin
            for (int i = 0; i < 3; i++) begin
                for (int j = 0; j < 3; j++) begin
                    int f1, f2, e;
                    f1 = (i == 0) ? 0 : (i == 1) ? 7 : 19;
                    f2 = (j == 0) ? 0 : (j == 1) ? 13 : 19;
                    e = (gap % (1 << CW)) * CLK_FINE + f1 - f2;
                    hit(1, 0, f1, 0);
                    idle(gap - 1);
                    hit(0, 1, 0, f2);
                    check("R7 not yet", int'(res_avail), 0);
                    idle(1);
                    pop_check(gap > 15 ? "R3 wrap" : "R2 interval", e);
                end
            end
        end

        // R4 replacement of held start
        hit(1, 0, 3, 0);
        idle(2);
        hit(1, 0, 11, 0);
        idle(1);
        hit(0, 1, 0, 5);
        idle(1);
        pop_check("R4 replace", 2*CLK_FINE + 11 - 5);
        check("R4 single", int'(res_avail), 0);

        // R5 stray stop
        hit(0, 1, 0, 4);
        idle(3);
        check("R5 stray", int'(res_avail), 0);

        // R6 simultaneous in idle: start only
        hit(1, 1, 6, 2);
        idle(2);
        hit(0, 1, 0, 1);
        idle(1);
        pop_check("R6 idle both", 3*CLK_FINE + 6 - 1);
        check("R6 idle both single", int'(res_avail), 0);

        // R6 simultaneous while armed; R8 back-to-back
        hit(1, 0, 4, 0);
        hit(1, 1, 9, 3);
        hit(0, 1, 0, 0);
        idle(1);
        pop_check("R6 armed both first", CLK_FINE + 4 - 3);
        pop_check("R6 armed both second", CLK_FINE + 9);
        check("R6 drained", int'(res_avail), 0);

        // R8 R9: one hit every other cycle per channel, fills buffer
        for (int k = 0; k < DEPTH; k++) begin
            hit(1, 0, k + 2, 0);
            hit(0, 1, 0, k);
        end
        idle(1);
        check("R9 full", int'(res_full), 1);
        check("R10 no overflow yet", int'(res_overflow), 0);
        for (int k = 0; k < DEPTH; k++) pop_check("R8 R9 order", CLK_FINE + 2);
        check("R9 not full", int'(res_full), 0);
        check("R9 empty", int'(res_avail), 0);

        // R10 overflow: DEPTH+1 results without popping
        for (int k = 0; k <= DEPTH; k++) begin
            hit(1, 0, k, 0);
            idle(1);
            hit(0, 1, 0, 0);
        end
        idle(1);
        check("R10 full", int'(res_full), 1);
        check("R10 overflow", int'(res_overflow), 1);
        for (int k = 0; k < DEPTH; k++) pop_check("R10 kept", 2*CLK_FINE + k);
        check("R10 dropped", int'(res_avail), 0);
        check("R10 sticky", int'(res_overflow), 1);

        // R11 pop on empty
        res_pop = 1'b1;
        idle(2);
        res_pop = 1'b0;
        check("R11 still empty", int'(res_avail), 0);
        hit(1, 0, 8, 0);
        idle(4);
        hit(0, 1, 0, 17);
        idle(1);
        pop_check("R11 after empty pop", 5*CLK_FINE + 8 - 17);
        check("R11 one entry", int'(res_avail), 0);

        // R1 reset clears overflow
        do_reset();
        check("R1 overflow cleared", int'(res_overflow), 0);
        check("R1 empty", int'(res_avail), 0);
        hit(0, 1, 0, 3);
        idle(2);
        check("R1 no held start", int'(res_avail), 0);

        report();
    end
endmodule